// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This engine files incoming frames into a circular list of receive descriptors kept in a descriptor memory. A MAC-side source presents each frame as a byte count plus CRC and framing error flags. The engine takes the descriptor at its current ring position and checks that the controller owns it. It compares the remaining byte count with the size of that descriptor's buffer, and chains into following descriptors when one buffer is too small. When the frame is done, it hands each used descriptor back to the host with start/end markers, the message length and error flags, and raises a one-cycle receive-interrupt event.

Payload bytes are not moved here. The engine only reads and writes descriptor words, through a single synchronous word port with one cycle of read latency. When no buffer is available at the start of a frame, the frame is dropped and a missed-frame event pulses. When buffers run out part-way through a frame, the frame is cut short and the last descriptor used is marked with buffer and overflow errors.

Top module: `rxRingEngine`

## Requirements
- R1: Descriptor memory is addressed as {index, select}, with select in the two low address bits. Select 1 holds {high base byte in bits 15:8, flag byte in bits 7:0}. Select 2 holds the buffer length as a two's complement value with bits 15:12 set; the buffer size is the low 12 bits of its negation. Select 3 holds the message length. Select 0 is never accessed. Every flag write keeps the high base byte that was read.
- R2: Flag bits are ENP=0x01, STP=0x02, BUFF=0x04, CRC=0x08, OFLO=0x10, FRAM=0x20, ERR=0x40 and OWN=0x80. OWN set means the controller owns the descriptor. The engine only ever writes OWN as 0.
- R3: A frame that fits in one buffer and has no errors leaves that descriptor's flag byte at exactly 0x03. Its message length word holds the frame byte count, FCS included, in the low 12 bits with the upper bits zero.
- R4: For a frame spread over several buffers, the first descriptor gets STP only (0x02), middle descriptors get 0x00, and the last gets ENP plus the CRC/FRAM flags and the message length. Message length words of non-final descriptors are left untouched.
- R5: ERR is set in a written flag byte exactly when at least one of BUFF, CRC, OFLO or FRAM is set.
- R6: If the current descriptor is host-owned when a frame arrives, the frame is dropped and missedFrame pulses for one cycle. No descriptor is modified, no rxInt pulse occurs, and the ring position does not move.
- R7: If a frame needs another buffer and the following descriptor is host-owned, the current descriptor gets BUFF|OFLO|ERR, plus STP if it is the first, and no ENP. Its message length is not written. The frame ends there, and the next frame starts at that following descriptor.
- R8: The message length of the final descriptor is written in the cycle immediately before its flag write, so ownership returns to the host only after every other field is in place.
- R9: The ring holds 2^n descriptors, where n is ringLenWord[15:13]; the other bits of that word are ignored. The position advances by one per used descriptor and wraps to 0 by masking.
- R10: rxInt pulses for exactly one cycle for each frame handed back, whether complete or cut short. frmReady is high only when idle, and no descriptor write happens while frmReady is high.
- R11: After reset the ring position is 0, frmReady is 1, rxInt and missedFrame are 0, and no memory access is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| ringLenWord | input | 16 | Ring-length word; bits 15:13 give log2 of the ring size |
| frmValid | input | 1 | A frame summary is presented |
| frmLen | input | 12 | Frame byte count including FCS |
| frmCrcErr | input | 1 | Frame had a CRC error |
| frmFramErr | input | 1 | Frame had a framing error |
| frmReady | output | 1 | Engine is idle and accepts a frame summary |
| memAddr | output | MAX_LOG+2 | Descriptor memory word address {index, select} |
| memRe | output | 1 | Read strobe; data returns one cycle later |
| memWe | output | 1 | Write strobe |
| memWdata | output | 16 | Write data |
| memRdata | input | 16 | Read data |
| rxInt | output | 1 | One-cycle receive-interrupt event |
| missedFrame | output | 1 | One-cycle missed-frame event |

## Verification
The bound checker watches every cycle for these invariants: the ERR summary matches the other error bits, no write sets OWN, a flag write carrying ENP comes straight after the message-length write to the same descriptor, a truncating write never carries ENP, addresses stay inside the current ring and off the base word, and the event pulses are single-cycle and mutually exclusive. Only the bench scenarios can show the exact flag pattern across one, two and three chained buffers, and that a dropped frame leaves the ring position where it was. They also show where a truncated frame resumes, that wrap follows bits 15:13 alone, and that unused descriptors and message words stay unchanged.

// File: rtl/rxRingPkg.sv
package rxRingPkg;
  // flag byte bit positions (shared with the host-side decoder)
  localparam int FL_ENP  = 0;
  localparam int FL_STP  = 1;
  localparam int FL_BUFF = 2;
  localparam int FL_CRC  = 3;
  localparam int FL_OFLO = 4;
  localparam int FL_FRAM = 5;
  localparam int FL_ERR  = 6;
  localparam int FL_OWN  = 7;

  // word selects inside one descriptor
  localparam logic [1:0] SEL_FLAG = 2'd1;
  localparam logic [1:0] SEL_BLEN = 2'd2;
  localparam logic [1:0] SEL_MLEN = 2'd3;

  // ring-length field position
  localparam int RING_LOG_HI = 15;
  localparam int RING_LOG_LO = 13;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_CUR,
    OP_RD_LEN,
    OP_RD_NXT,
    OP_WR_MSG,
    OP_WR_MID,
    OP_WR_LAST,
    OP_WR_TRUNC
  } memOp_e;

  typedef struct packed {
    memOp_e op;
    logic   loadFrame;
    logic   latchCurHi;
    logic   latchSize;
    logic   latchNxtHi;
    logic   stepBuf;
    logic   finish;
    logic   rxDone;
    logic   missed;
  } ctlStrobe_t;
endpackage

// File: rtl/rxRingCtl.sv
module rxRingCtl
  import rxRingPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frmValid,
  input  logic       rdOwn,
  input  logic       fits,
  output logic       frmReady,
  output ctlStrobe_t stb
);

  typedef enum logic [3:0] {
    S_IDLE,
    S_CUR_REQ,
    S_CUR_CHK,
    S_LEN_REQ,
    S_LEN_CHK,
    S_NXT_REQ,
    S_NXT_CHK,
    S_MID_WR,
    S_TRUNC_WR,
    S_MSG_WR,
    S_LAST_WR
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    stb       = '0;
    stb.op    = OP_NONE;
    frmReady  = (state == S_IDLE);
    case (state)
      S_IDLE: begin
        if (frmValid) begin
          stb.loadFrame = 1'b1;
          nextState     = S_CUR_REQ;
        end
      end
      S_CUR_REQ: begin
        stb.op    = OP_RD_CUR;
        nextState = S_CUR_CHK;
      end
      S_CUR_CHK: begin
        if (rdOwn) begin
          stb.latchCurHi = 1'b1;
          nextState      = S_LEN_REQ;
        end else begin
          stb.missed = 1'b1;
          nextState  = S_IDLE;
        end
      end
      S_LEN_REQ: begin
        stb.op    = OP_RD_LEN;
        nextState = S_LEN_CHK;
      end
      S_LEN_CHK: begin
        stb.latchSize = 1'b1;
        nextState     = fits ? S_MSG_WR : S_NXT_REQ;
      end
      S_NXT_REQ: begin
        stb.op    = OP_RD_NXT;
        nextState = S_NXT_CHK;
      end
      S_NXT_CHK: begin
        stb.latchNxtHi = 1'b1;
        nextState      = rdOwn ? S_MID_WR : S_TRUNC_WR;
      end
      S_MID_WR: begin
        stb.op      = OP_WR_MID;
        stb.stepBuf = 1'b1;
        nextState   = S_LEN_REQ;
      end
      S_TRUNC_WR: begin
        stb.op     = OP_WR_TRUNC;
        stb.finish = 1'b1;
        stb.rxDone = 1'b1;
        nextState  = S_IDLE;
      end
      S_MSG_WR: begin
        stb.op    = OP_WR_MSG;
        nextState = S_LAST_WR;
      end
      S_LAST_WR: begin
        stb.op     = OP_WR_LAST;
        stb.finish = 1'b1;
        stb.rxDone = 1'b1;
        nextState  = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/rxRingDp.sv
module rxRingDp
  import rxRingPkg::*;
#(
  parameter int MAX_LOG = 7,
  parameter int LEN_W   = 12,
  parameter int DATA_W  = 16,
  localparam int AW     = MAX_LOG + 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [2:0]        ringLog,
  input  logic [LEN_W-1:0]  frmLen,
  input  logic              frmCrcErr,
  input  logic              frmFramErr,
  input  logic [DATA_W-1:0] memRdata,
  output logic [AW-1:0]     memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              rdOwn,
  output logic              fits,
  output logic              rxInt,
  output logic              missedFrame
);

  logic [MAX_LOG-1:0] curIdx, nxtIdx, ringMask;
  logic [LEN_W-1:0]   frameLen, remaining, bufSize, sizeNow;
  logic [DATA_W-1:0]  negLen;
  logic               crcE, framE, first;
  logic [7:0]         curHi, nxtHi;
  logic [7:0]         flagMid, flagLast, flagTrunc;

  // ring mask from log2 field
  always_comb begin
    ringMask = '0;
    for (int b = 0; b < MAX_LOG; b++)
      if (b < int'(ringLog)) ringMask[b] = 1'b1;
  end

  assign nxtIdx  = (curIdx + 1'b1) & ringMask;
  assign negLen  = '0 - memRdata;
  assign sizeNow = negLen[LEN_W-1:0];
  assign fits    = (sizeNow == '0) || (remaining <= sizeNow);
  assign rdOwn   = memRdata[FL_OWN];

  always_comb begin
    flagMid             = '0;
    flagMid[FL_STP]     = first;
    flagLast            = '0;
    flagLast[FL_STP]    = first;
    flagLast[FL_ENP]    = 1'b1;
    flagLast[FL_CRC]    = crcE;
    flagLast[FL_FRAM]   = framE;
    flagLast[FL_ERR]    = crcE | framE;
    flagTrunc           = '0;
    flagTrunc[FL_STP]   = first;
    flagTrunc[FL_BUFF]  = 1'b1;
    flagTrunc[FL_OFLO]  = 1'b1;
    flagTrunc[FL_ERR]   = 1'b1;
  end

  always_comb begin
    memAddr  = {curIdx, SEL_FLAG};
    memRe    = 1'b0;
    memWe    = 1'b0;
    memWdata = '0;
    case (stb.op)
      OP_RD_CUR:   begin memRe = 1'b1; memAddr = {curIdx, SEL_FLAG}; end
      OP_RD_LEN:   begin memRe = 1'b1; memAddr = {curIdx, SEL_BLEN}; end
      OP_RD_NXT:   begin memRe = 1'b1; memAddr = {nxtIdx, SEL_FLAG}; end
      OP_WR_MSG:   begin
        memWe    = 1'b1;
        memAddr  = {curIdx, SEL_MLEN};
        memWdata = DATA_W'(frameLen);
      end
      OP_WR_MID:   begin memWe = 1'b1; memWdata = DATA_W'({curHi, flagMid}); end
      OP_WR_LAST:  begin memWe = 1'b1; memWdata = DATA_W'({curHi, flagLast}); end
      OP_WR_TRUNC: begin memWe = 1'b1; memWdata = DATA_W'({curHi, flagTrunc}); end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curIdx      <= '0;
      frameLen    <= '0;
      remaining   <= '0;
      bufSize     <= '0;
      crcE        <= 1'b0;
      framE       <= 1'b0;
      first       <= 1'b0;
      curHi       <= '0;
      nxtHi       <= '0;
      rxInt       <= 1'b0;
      missedFrame <= 1'b0;
    end else begin
      rxInt       <= stb.rxDone;
      missedFrame <= stb.missed;
      if (stb.loadFrame) begin
        frameLen  <= frmLen;
        remaining <= frmLen;
        crcE      <= frmCrcErr;
        framE     <= frmFramErr;
        first     <= 1'b1;
      end
      if (stb.latchCurHi) curHi   <= memRdata[15:8];
      if (stb.latchSize)  bufSize <= sizeNow;
      if (stb.latchNxtHi) nxtHi   <= memRdata[15:8];
      if (stb.stepBuf) begin
        curIdx    <= nxtIdx;
        remaining <= remaining - bufSize;
        first     <= 1'b0;
        curHi     <= nxtHi;
      end
      if (stb.finish) curIdx <= nxtIdx;
    end
  end

endmodule

// File: rtl/rxRingEngine.sv
module rxRingEngine
  import rxRingPkg::*;
#(
  parameter int MAX_LOG = 7,
  parameter int LEN_W   = 12,
  parameter int DATA_W  = 16
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [15:0]          ringLenWord,
  input  logic                 frmValid,
  input  logic [LEN_W-1:0]     frmLen,
  input  logic                 frmCrcErr,
  input  logic                 frmFramErr,
  output logic                 frmReady,
  output logic [MAX_LOG+1:0]   memAddr,
  output logic                 memRe,
  output logic                 memWe,
  output logic [DATA_W-1:0]    memWdata,
  input  logic [DATA_W-1:0]    memRdata,
  output logic                 rxInt,
  output logic                 missedFrame
);

  ctlStrobe_t stb;
  logic       rdOwn, fits;
  logic       unusedCfg;

  assign unusedCfg = ^ringLenWord[RING_LOG_LO-1:0];

  rxRingCtl uCtl (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .rdOwn    (rdOwn),
    .fits     (fits),
    .frmReady (frmReady),
    .stb      (stb)
  );

  rxRingDp #(
    .MAX_LOG (MAX_LOG),
    .LEN_W   (LEN_W),
    .DATA_W  (DATA_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .ringLog     (ringLenWord[RING_LOG_HI:RING_LOG_LO]),
    .frmLen      (frmLen),
    .frmCrcErr   (frmCrcErr),
    .frmFramErr  (frmFramErr),
    .memRdata    (memRdata),
    .memAddr     (memAddr),
    .memRe       (memRe),
    .memWe       (memWe),
    .memWdata    (memWdata),
    .rdOwn       (rdOwn),
    .fits        (fits),
    .rxInt       (rxInt),
    .missedFrame (missedFrame)
  );

endmodule

// File: rtl/rxRingChk.sv
module rxRingChk #(
  parameter int MAX_LOG = 7
)(
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         ringLog,
  input logic               frmReady,
  input logic [MAX_LOG+1:0] memAddr,
  input logic               memRe,
  input logic               memWe,
  input logic [15:0]        memWdata,
  input logic               rxInt,
  input logic               missedFrame
);

  logic [MAX_LOG-1:0] mask;
  logic               prevWrValid;
  logic [MAX_LOG+1:0] prevWrAddr;

  always_comb begin
    mask = '0;
    for (int b = 0; b < MAX_LOG; b++)
      if (b < int'(ringLog)) mask[b] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWrValid <= 1'b0;
      prevWrAddr  <= '0;
    end else begin
      prevWrValid <= memWe;
      prevWrAddr  <= memAddr;
    end
  end

  assert_no_base_word_R1: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> (memAddr[1:0] != 2'd0));

  assert_single_port_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  assert_own_never_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[1:0] == 2'd1) |-> !memWdata[7]);

  assert_err_summary_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[1:0] == 2'd1) |-> (memWdata[6] == (|memWdata[5:2])));

  assert_trunc_no_enp_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[1:0] == 2'd1 && memWdata[2]) |-> (!memWdata[0] && memWdata[4]));

  assert_msg_before_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memAddr[1:0] == 2'd1 && memWdata[0]) |->
      (prevWrValid && prevWrAddr == {memAddr[MAX_LOG+1:2], 2'd3}));

  assert_index_in_ring_R9: assert property (@(posedge clk) disable iff (!rstN)
    (memRe || memWe) |-> ((memAddr[MAX_LOG+1:2] & ~mask) == '0));

  assert_rx_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rxInt |=> !rxInt);

  assert_miss_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    missedFrame |=> !missedFrame);

  assert_events_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(rxInt && missedFrame));

  assert_no_write_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !frmReady);

endmodule

bind rxRingEngine rxRingChk #(.MAX_LOG(MAX_LOG)) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .ringLog     (ringLenWord[15:13]),
  .frmReady    (frmReady),
  .memAddr     (memAddr),
  .memRe       (memRe),
  .memWe       (memWe),
  .memWdata    (memWdata),
  .rxInt       (rxInt),
  .missedFrame (missedFrame)
);

// File: tb/sim_rxRingEngine.sv
`timescale 1ns/1ps
module sim_rxRingEngine;

  logic        clk = 1'b0;
  logic        rstN;
  logic [15:0] ringLenWord;
  logic        frmValid;
  logic [11:0] frmLen;
  logic        frmCrcErr, frmFramErr;
  logic        frmReady;
  logic [8:0]  memAddr;
  logic        memRe, memWe;
  logic [15:0] memWdata;
  logic [15:0] memRdata;
  logic        rxInt, missedFrame;

  logic [15:0] mem [0:511];

  int checks = 0;
  int fails  = 0;
  int rxCnt  = 0;
  int missCnt = 0;

  always #10 clk = ~clk;

  rxRingEngine u0 (
    .clk(clk), .rstN(rstN), .ringLenWord(ringLenWord),
    .frmValid(frmValid), .frmLen(frmLen), .frmCrcErr(frmCrcErr), .frmFramErr(frmFramErr),
    .frmReady(frmReady), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWdata(memWdata), .memRdata(memRdata), .rxInt(rxInt), .missedFrame(missedFrame)
  );

  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWdata;
    if (memRe) memRdata <= mem[memAddr];
    if (rxInt) rxCnt++;
    if (missedFrame) missCnt++;
  end

  // {len12, crc, fram, nbuf4, lastFlag8}; all buffers 128 bytes
  localparam logic [25:0] VEC [0:6] = '{
    {12'd64,  1'b0, 1'b0, 4'd1, 8'h03},
    {12'd128, 1'b0, 1'b0, 4'd1, 8'h03},
    {12'd129, 1'b0, 1'b0, 4'd2, 8'h01},
    {12'd300, 1'b1, 1'b0, 4'd3, 8'h49},
    {12'd100, 1'b0, 1'b1, 4'd1, 8'h63},
    {12'd90,  1'b1, 1'b1, 4'd1, 8'h6B},
    {12'd256, 1'b0, 1'b1, 4'd2, 8'h61}
  };

  function automatic int fa(int idx); return idx * 4 + 1; endfunction
  function automatic int ma(int idx); return idx * 4 + 3; endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setDesc(int idx, bit own);
    logic [15:0] blen;
    blen = 16'hF000 | (16'h0000 - 16'd128);
    mem[idx*4]   = 16'h1000 + 16'(idx);
    mem[fa(idx)] = {8'hA0 + 8'(idx), own ? 8'h80 : 8'h00};
    mem[idx*4+2] = blen;
    mem[ma(idx)] = 16'hBEEF;
  endtask

  task automatic initDescs(int nOwned);
    for (int i = 0; i < 16; i++) setDesc(i, i < nOwned);
  endtask

  task automatic sendFrame(logic [11:0] len, logic crc, logic fram);
    int guard;
    @(negedge clk);
    frmLen = len; frmCrcErr = crc; frmFramErr = fram; frmValid = 1'b1;
    @(negedge clk);
    frmValid = 1'b0;
    guard = 0;
    while (!frmReady && guard < 1000) begin @(negedge clk); guard++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int expIdx, rx0, ms0;
    rstN = 1'b0; frmValid = 1'b0; frmLen = '0; frmCrcErr = 1'b0; frmFramErr = 1'b0;
    ringLenWord = 16'h6000 | 16'h0155;   // n=3, low bits junk (R9)
    initDescs(8);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 frmReady", 16'(frmReady), 16'd1);
    chk("R11 rxInt", 16'(rxInt), 16'd0);
    chk("R11 missedFrame", 16'(missedFrame), 16'd0);
    chk("R11 memRe/memWe", 16'({memRe, memWe}), 16'd0);

    // table walk: R2 R3 R4 R5 R9
    expIdx = 0;
    for (int v = 0; v < 7; v++) begin
      logic [11:0] len; logic crc, fram; int nb; logic [7:0] lastF;
      {len, crc, fram} = VEC[v][25:12];
      nb = int'(VEC[v][11:8]);
      lastF = VEC[v][7:0];
      rx0 = rxCnt; ms0 = missCnt;
      sendFrame(len, crc, fram);
      chk("R10 one rxInt per frame", 16'(rxCnt - rx0), 16'd1);
      chk("R6 no missed on good ring", 16'(missCnt - ms0), 16'd0);
      for (int k = 0; k < nb; k++) begin
        int d;
        logic [7:0] ef;
        d = (expIdx + k) & 7;
        ef = (k == nb - 1) ? lastF : ((k == 0) ? 8'h02 : 8'h00);
        chk("R2 R3 R4 R5 flag byte", {8'h00, mem[fa(d)][7:0]}, {8'h00, ef});
        chk("R1 high base byte kept", {8'h00, mem[fa(d)][15:8]}, {8'h00, 8'hA0 + 8'(d)});
        if (k == nb - 1) chk("R3 R4 R8 final msgLen", mem[ma(d)], {4'h0, len});
        else             chk("R4 non-final msgLen untouched", mem[ma(d)], 16'hBEEF);
        setDesc(d, 1'b1);
      end
      expIdx = (expIdx + nb) & 7;
    end
    chk("R9 desc 8 outside ring untouched", mem[fa(8)], 16'hA800);

    // R6 missed frame: host owns current descriptor
    setDesc(expIdx, 1'b0);
    rx0 = rxCnt; ms0 = missCnt;
    sendFrame(12'd64, 1'b0, 1'b0);
    chk("R6 missed pulse", 16'(missCnt - ms0), 16'd1);
    chk("R6 no rxInt on drop", 16'(rxCnt - rx0), 16'd0);
    chk("R6 descriptor untouched", mem[fa(expIdx)], {8'hA0 + 8'(expIdx), 8'h00});
    chk("R6 msgLen untouched", mem[ma(expIdx)], 16'hBEEF);
    setDesc(expIdx, 1'b1);
    sendFrame(12'd70, 1'b0, 1'b0);
    chk("R6 position held, next frame lands", {8'h00, mem[fa(expIdx)][7:0]}, 16'h0003);
    chk("R6 next frame msgLen", mem[ma(expIdx)], 16'd70);
    setDesc(expIdx, 1'b1);
    expIdx = (expIdx + 1) & 7;

    // R7 truncation on first buffer
    setDesc((expIdx + 1) & 7, 1'b0);
    rx0 = rxCnt;
    sendFrame(12'd300, 1'b0, 1'b0);
    chk("R7 rxInt on truncation", 16'(rxCnt - rx0), 16'd1);
    chk("R7 truncated flags STP|BUFF|OFLO|ERR", {8'h00, mem[fa(expIdx)][7:0]}, 16'h0056);
    chk("R7 truncated msgLen untouched", mem[ma(expIdx)], 16'hBEEF);
    chk("R7 host-owned next untouched", mem[fa((expIdx + 1) & 7)],
        {8'hA0 + 8'((expIdx + 1) & 7), 8'h00});
    setDesc(expIdx, 1'b1);
    expIdx = (expIdx + 1) & 7;
    setDesc(expIdx, 1'b1);
    sendFrame(12'd64, 1'b0, 1'b0);
    chk("R7 next frame starts at following descriptor", {8'h00, mem[fa(expIdx)][7:0]}, 16'h0003);
    setDesc(expIdx, 1'b1);
    expIdx = (expIdx + 1) & 7;

    // R7 truncation on a middle buffer
    setDesc((expIdx + 2) & 7, 1'b0);
    sendFrame(12'd300, 1'b1, 1'b0);
    chk("R7 first of truncated chain STP", {8'h00, mem[fa(expIdx)][7:0]}, 16'h0002);
    chk("R7 middle truncated BUFF|OFLO|ERR", {8'h00, mem[fa((expIdx + 1) & 7)][7:0]}, 16'h0054);
    chk("R7 middle truncated msgLen untouched", mem[ma((expIdx + 1) & 7)], 16'hBEEF);

    // R9 smaller ring, selected by bits 15:13 only
    rstN = 1'b0;
    ringLenWord = 16'h5FFF;   // n=2 -> 4 descriptors
    initDescs(8);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    for (int f = 0; f < 5; f++) begin
      sendFrame(12'd61 + 12'(f), 1'b0, 1'b0);
      if (f < 4) setDesc(f, 1'b1);
    end
    chk("R9 wrap to descriptor 0 msgLen", mem[ma(0)], 16'd65);
    chk("R9 wrap to descriptor 0 flags", {8'h00, mem[fa(0)][7:0]}, 16'h0003);
    chk("R9 descriptor 4 unused", mem[ma(4)], 16'hBEEF);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule